// File: doc/BRIEF.md
# Timer-Compare CSR Access Permission Checker

This block sits in a processor's CSR decode path and rules on each CSR access request before the register file is touched. It checks the privilege level encoded in the CSR number against the current privilege mode and the virtualization bit. It also tests writes to read-only numbers. For the two supervisor timer-compare registers it adds the cascaded machine-level and hypervisor-level timer-enable gates. It returns one verdict: permitted, illegal-instruction fault or virtual-instruction fault. A permitted supervisor-numbered access made while virtualized also raises a redirect flag, so that the virtual-supervisor copy serves the access.

The verdict is registered. A request presented with `req_valid_i` high in one cycle gives its response on the outputs after the next rising clock edge. In any cycle after an edge where no request was presented, the outputs are all zero. The CSR storage and the trap entry sequence are outside this block.

Top module: `csr_tcmp_access`

## Requirements
- R1: A request sampled with `req_valid_i`=1 at a rising edge gives `rsp_valid_o`=1 with its verdict after that edge. After an edge with `req_valid_i`=0, `rsp_valid_o`, `allow_o`, `fault_o` and `redirect_o` are all 0.
- R2: `fault_o` encodes 2'b00 none, 2'b01 illegal instruction, 2'b10 virtual instruction, and never 2'b11. `allow_o`=1 exactly when a response carries fault 2'b00.
- R3: Privilege mode `priv_i`=2'b11 (machine) is permitted for every CSR, regardless of `virt_i` and of both enable bits, except as R4 states.
- R4: A write (`csr_we_i`=1) to a number whose bits [11:10] are 2'b11 is an illegal-instruction fault in every mode.
- R5: Bits [9:8] of the CSR number give the lowest level allowed. With `virt_i`=0, `priv_i`=2'b01 acts at level 2 and any other non-machine value acts at level 0. A level above the acting level is an illegal-instruction fault.
- R6: With `virt_i`=1 in a non-machine mode, level 3 is an illegal-instruction fault and level 2 is a virtual-instruction fault. A user mode accessing level 1 is also a virtual-instruction fault.
- R7: An access to 0x14D or 0x24D from a non-machine mode while `menv_tce_i`=0 is an illegal-instruction fault.
- R8: With `menv_tce_i`=1, `henv_tce_i`=0 and `virt_i`=1, a non-machine access to 0x14D is a virtual-instruction fault. `henv_tce_i` has no effect when `menv_tce_i`=0 or when `virt_i`=0.
- R9: When an access meets both an illegal-instruction cause and a virtual-instruction cause, the fault is illegal instruction.
- R10: `redirect_o`=1 exactly when a permitted response came from a non-machine mode with `virt_i`=1 and CSR level 1.
- R11: A user mode never accesses 0x14D or 0x24D. The fault is illegal instruction with `virt_i`=0 and virtual instruction with `virt_i`=1 (when `menv_tce_i`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present |
| csr_num_i | input | 12 | CSR number |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 2 | Current mode: 2'b00 user, 2'b01 supervisor, 2'b11 machine (2'b10 acts as user) |
| virt_i | input | 1 | Virtualization bit |
| menv_tce_i | input | 1 | Machine-level timer-compare enable |
| henv_tce_i | input | 1 | Hypervisor-level timer-compare enable |
| rsp_valid_o | output | 1 | Verdict present |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 2 | Fault code (R2) |
| redirect_o | output | 1 | Serve from the virtual-supervisor copy |

## Verification
The block holds no state beyond the response register, so a fault in the decode shows up as a wrong verdict on the very next response. There is no lasting corruption to catch later. A broken enable cascade shows only when a timer-compare number meets the matching enable and virtualization combination. A swapped precedence shows only when both fault causes apply at once. The bench therefore drives every such combination directly and then sweeps random numbers, modes and enables, comparing each response one cycle after its request.

// File: rtl/csr_tcmp_pkg.sv
package csr_tcmp_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_ILL  = 2'b01,
    FLT_VIRT = 2'b10
  } fault_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/csr_lvl_chk.sv
module csr_lvl_chk #(
  parameter int CSR_W = 12
) (
  input  logic [CSR_W-1:0] csr_num_i,
  input  logic             csr_we_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  output logic             ill_o,
  output logic             vflt_o,
  output logic             redir_cand_o
);
  import csr_tcmp_pkg::*;
  localparam int RO_HI  = CSR_W - 1;
  localparam int LVL_HI = CSR_W - 3;

  logic [1:0] lvl;
  logic       is_m, is_s, ro_wr;
  logic [1:0] acting;

  assign lvl   = csr_num_i[LVL_HI -: 2];
  assign is_m  = (priv_i == PRIV_M);
  assign is_s  = (priv_i == PRIV_S);
  assign ro_wr = csr_we_i && (csr_num_i[RO_HI -: 2] == 2'b11);
  assign acting = is_s ? 2'd2 : 2'd0;

  always_comb begin
    ill_o  = ro_wr;
    vflt_o = 1'b0;
    if (!is_m) begin
      if (!virt_i) begin
        ill_o = ro_wr || (lvl > acting);
      end else begin
        ill_o  = ro_wr || (lvl == 2'd3);
        vflt_o = (lvl == 2'd2) || (!is_s && lvl == 2'd1);
      end
    end
  end

  assign redir_cand_o = !is_m && virt_i && (lvl == 2'd1);
endmodule

// File: rtl/csr_tcmp_gate.sv
module csr_tcmp_gate #(
  parameter int               CSR_W     = 12,
  parameter logic [CSR_W-1:0] S_CMP_NUM  = 12'h14D,
  parameter logic [CSR_W-1:0] VS_CMP_NUM = 12'h24D
) (
  input  logic [CSR_W-1:0] csr_num_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             menv_tce_i,
  input  logic             henv_tce_i,
  output logic             ill_o,
  output logic             vflt_o
);
  import csr_tcmp_pkg::*;
  logic hit_s, hit_vs, non_m, henv_eff;

  assign hit_s    = (csr_num_i == S_CMP_NUM);
  assign hit_vs   = (csr_num_i == VS_CMP_NUM);
  assign non_m    = (priv_i != PRIV_M);
  // hypervisor enable reads as zero while the machine enable is clear
  assign henv_eff = menv_tce_i && henv_tce_i;

  assign ill_o  = non_m && (hit_s || hit_vs) && !menv_tce_i;
  assign vflt_o = non_m && hit_s && virt_i && menv_tce_i && !henv_eff;
endmodule

// File: rtl/csr_fault_merge.sv
module csr_fault_merge (
  input  logic                    lvl_ill_i,
  input  logic                    lvl_vflt_i,
  input  logic                    gate_ill_i,
  input  logic                    gate_vflt_i,
  input  logic                    redir_cand_i,
  output csr_tcmp_pkg::fault_e    fault_o,
  output logic                    allow_o,
  output logic                    redir_o
);
  import csr_tcmp_pkg::*;
  always_comb begin
    if (lvl_ill_i || gate_ill_i)        fault_o = FLT_ILL;
    else if (lvl_vflt_i || gate_vflt_i) fault_o = FLT_VIRT;
    else                                fault_o = FLT_NONE;
  end
  assign allow_o = (fault_o == FLT_NONE);
  assign redir_o = allow_o && redir_cand_i;
endmodule

// File: rtl/csr_tcmp_access.sv
module csr_tcmp_access #(
  parameter int               CSR_W      = 12,
  parameter logic [CSR_W-1:0] S_CMP_NUM  = 12'h14D,
  parameter logic [CSR_W-1:0] VS_CMP_NUM = 12'h24D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [CSR_W-1:0] csr_num_i,
  input  logic             csr_we_i,
  input  logic [1:0]       priv_i,
  input  logic             virt_i,
  input  logic             menv_tce_i,
  input  logic             henv_tce_i,
  output logic             rsp_valid_o,
  output logic             allow_o,
  output logic [1:0]       fault_o,
  output logic             redirect_o
);
  import csr_tcmp_pkg::*;

  logic   lvl_ill, lvl_vflt, redir_cand, gate_ill, gate_vflt;
  logic   allow_d, redir_d;
  fault_e fault_d;

  csr_lvl_chk #(.CSR_W(CSR_W)) u_lvl (
    .csr_num_i    (csr_num_i),
    .csr_we_i     (csr_we_i),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .ill_o        (lvl_ill),
    .vflt_o       (lvl_vflt),
    .redir_cand_o (redir_cand)
  );

  csr_tcmp_gate #(
    .CSR_W(CSR_W), .S_CMP_NUM(S_CMP_NUM), .VS_CMP_NUM(VS_CMP_NUM)
  ) u_gate (
    .csr_num_i  (csr_num_i),
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .menv_tce_i (menv_tce_i),
    .henv_tce_i (henv_tce_i),
    .ill_o      (gate_ill),
    .vflt_o     (gate_vflt)
  );

  csr_fault_merge u_merge (
    .lvl_ill_i    (lvl_ill),
    .lvl_vflt_i   (lvl_vflt),
    .gate_ill_i   (gate_ill),
    .gate_vflt_i  (gate_vflt),
    .redir_cand_i (redir_cand),
    .fault_o      (fault_d),
    .allow_o      (allow_d),
    .redir_o      (redir_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      allow_o     <= 1'b0;
      fault_o     <= 2'b00;
      redirect_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      allow_o     <= req_valid_i && allow_d;
      fault_o     <= req_valid_i ? fault_d : 2'b00;
      redirect_o  <= req_valid_i && redir_d;
    end
  end
endmodule

// File: rtl/csr_tcmp_chk.sv
module csr_tcmp_chk #(
  parameter int CSR_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [CSR_W-1:0] csr_num_i,
  input logic             csr_we_i,
  input logic [1:0]       priv_i,
  input logic             virt_i,
  input logic             menv_tce_i,
  input logic             rsp_valid_o,
  input logic             allow_o,
  input logic [1:0]       fault_o,
  input logic             redirect_o
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !allow_o && fault_o == 2'b00 && !redirect_o));

  p_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o != 2'b11);

  p_m_allow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i == 2'b11 && csr_num_i[CSR_W-1 -: 2] != 2'b11) |=> allow_o);

  p_vs_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i == 2'b01 && virt_i && menv_tce_i &&
     csr_num_i[CSR_W-3 -: 2] == 2'b10 && csr_num_i[CSR_W-1 -: 2] != 2'b11)
    |=> fault_o == 2'b10);

  p_menv_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i != 2'b11 && !menv_tce_i &&
     (csr_num_i == 12'h14D || csr_num_i == 12'h24D)) |=> fault_o == 2'b01);

  p_redir_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (allow_o && rsp_valid_o));
endmodule

bind csr_tcmp_access csr_tcmp_chk #(.CSR_W(CSR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .csr_num_i(csr_num_i), .csr_we_i(csr_we_i), .priv_i(priv_i),
  .virt_i(virt_i), .menv_tce_i(menv_tce_i), .rsp_valid_o(rsp_valid_o),
  .allow_o(allow_o), .fault_o(fault_o), .redirect_o(redirect_o)
);

// File: tb/sim_csr_tcmp_access.sv
`timescale 1ns/1ps
module sim_csr_tcmp_access;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_v = 1'b0, we = 1'b0, virt = 1'b0, menv = 1'b0, henv = 1'b0;
  logic [11:0] num = '0;
  logic [1:0]  priv = 2'b00;
  logic rsp_v, allow, redir;
  logic [1:0] fault;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csr_tcmp_access u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_v), .csr_num_i(num),
    .csr_we_i(we), .priv_i(priv), .virt_i(virt), .menv_tce_i(menv),
    .henv_tce_i(henv), .rsp_valid_o(rsp_v), .allow_o(allow),
    .fault_o(fault), .redirect_o(redir)
  );

  // reference verdict from the requirements: {fault[1:0], redirect}
  function automatic logic [2:0] ref_verdict(logic [11:0] n, logic w, logic [1:0] p,
                                             logic v, logic me, logic he);
    bit ill = 0, vf = 0, machine, sup, cmp;
    int lvl, act;
    machine = (p == 2'b11);
    sup     = (p == 2'b01);
    cmp     = (n == 12'h14D) || (n == 12'h24D);
    lvl     = n[9:8];
    if (w && n[11:10] == 2'b11) ill = 1;                 // R4
    if (!machine) begin
      if (!v) begin
        act = sup ? 2 : 0;
        if (lvl > act) ill = 1;                          // R5
      end else begin
        if (lvl == 3) ill = 1;                           // R6
        if (lvl == 2) vf = 1;
        if (!sup && lvl == 1) vf = 1;
      end
      if (cmp && !me) ill = 1;                           // R7
      if (n == 12'h14D && v && me && !he) vf = 1;        // R8
    end
    if (ill) return 3'b010;                              // R9
    if (vf)  return 3'b100;
    return {2'b00, (!machine && v && lvl == 1)};         // R10
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    logic [1:0] ef = exp[2:1];
    n_chk++;
    if (rsp_v !== 1'b1 || fault !== ef || allow !== (ef == 2'b00) || redir !== exp[0]) begin
      n_err++;
      $display("FAIL %s: got v=%b f=%b a=%b r=%b exp v=1 f=%b a=%b r=%b num=%h p=%b V=%b me=%b he=%b we=%b",
               tag, rsp_v, fault, allow, redir, ef, (ef == 2'b00), exp[0],
               num, priv, virt, menv, henv, we);
    end
  endtask

  // drive at negedge, check one cycle later at negedge
  task automatic req(string tag, logic [11:0] n, logic w, logic [1:0] p,
                     logic v, logic me, logic he);
    num = n; we = w; priv = p; virt = v; menv = me; henv = he; req_v = 1'b1;
    @(negedge clk);
    chk(tag, ref_verdict(n, w, p, v, me, he));
  endtask

  task automatic idle_chk(string tag);
    req_v = 1'b0;
    num = 12'h14D; priv = 2'b01; virt = 1'b1; menv = 1'b1; henv = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rsp_v !== 1'b0 || allow !== 1'b0 || fault !== 2'b00 || redir !== 1'b0) begin
      n_err++;
      $display("FAIL %s: got v=%b a=%b f=%b r=%b exp all 0", tag, rsp_v, allow, fault, redir);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    n_chk++;
    if (rsp_v !== 1'b0 || allow !== 1'b0 || fault !== 2'b00 || redir !== 1'b0) begin
      n_err++; $display("FAIL R1 reset: got v=%b a=%b f=%b r=%b exp 0", rsp_v, allow, fault, redir);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 idle");

    req("R3 M, enables off",        12'h14D, 1, 2'b11, 0, 0, 0);
    req("R3 M with V set",          12'h24D, 1, 2'b11, 1, 0, 0);
    req("R4 M write read-only",     12'hF11, 1, 2'b11, 0, 1, 1);
    req("R4 M read read-only",      12'hF11, 0, 2'b11, 0, 1, 1);
    req("R5 HS to hyp level",       12'h24D, 0, 2'b01, 0, 1, 0);
    req("R8 henv ignored V=0",      12'h14D, 1, 2'b01, 0, 1, 0);
    req("R5 HS to machine level",   12'h300, 0, 2'b01, 0, 1, 1);
    req("R7 HS menv off",           12'h24D, 0, 2'b01, 0, 0, 1);
    req("R7 HS menv off S num",     12'h14D, 0, 2'b01, 0, 0, 1);
    req("R10 VS allowed redirect",  12'h14D, 1, 2'b01, 1, 1, 1);
    req("R8 VS henv off",           12'h14D, 0, 2'b01, 1, 1, 0);
    req("R6 VS direct VS number",   12'h24D, 0, 2'b01, 1, 1, 1);
    req("R9 VS menv off precedence",12'h14D, 0, 2'b01, 1, 0, 1);
    req("R8 henv ignored menv off", 12'h14D, 0, 2'b01, 1, 0, 0);
    req("R6 VS machine level",      12'h344, 0, 2'b01, 1, 1, 1);
    req("R11 U V=0",                12'h14D, 0, 2'b00, 0, 1, 1);
    req("R11 VU",                   12'h14D, 0, 2'b00, 1, 1, 1);
    req("R11 VU VS number",         12'h24D, 1, 2'b00, 1, 1, 1);
    req("R9 VU menv off",           12'h14D, 0, 2'b00, 1, 0, 1);
    req("R10 VS other S number",    12'h140, 1, 2'b01, 1, 0, 0);
    req("R5 U user level",          12'hC01, 0, 2'b00, 0, 0, 0);
    req("R4 VS write read-only",    12'hD40, 1, 2'b01, 1, 1, 1);
    idle_chk("R1 idle after burst");

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] n;
      logic [1:0]  p;
      case ($urandom_range(0, 3))
        0: n = 12'h14D;
        1: n = 12'h24D;
        default: n = 12'($urandom);
      endcase
      p = 2'($urandom);
      req("R2 random", n, 1'($urandom), p, 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(0, 15) == 0) idle_chk("R1 random idle");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule